// File: doc/BRIEF.md
# Serial SAR Converter Link Sequencer

This block is the host side of a four-wire serial link to a multichannel 14-bit successive-approximation converter. It takes one conversion request at a time. Each request carries a channel number, a single-ended or differential flag, a unipolar or bipolar flag and two power-down bits. From these the block builds an 8-bit command that begins with a start bit. It lowers chip select and clocks the command out on the data-out line. It then keeps the serial clock running through the conversion, shifts in the 14 result bits, and returns the result widened to the output width with a one-cycle valid strobe.

The serial clock comes from the system clock through a programmable divider. In plain mode every conversion takes its own 24-clock frame. A request can instead ask for overlapped operation. In that case a following request is taken at the end of the eighteenth clock. Its command then starts while the last five bits of the earlier result are still arriving, so back-to-back conversions cost 18 serial clocks each. Analog behaviour, reference handling and the converter's self-clocked mode are outside this block.

Top module: `sar_link_ctrl`

## Requirements
- R1: The command byte is sent most significant bit first. From bit 7 down to bit 0 it is: a constant 1 start bit, the 3-bit channel (bits 6:4), the single-ended flag (bit 3, 1 = single-ended), the unipolar flag (bit 2, 1 = unipolar) and the 2 power-down bits (bits 1:0). The channel and mode fields are copied without decoding.
- R2: The serial clock stays low while chip select is high. Once chip select falls, the clock alternates low and high phases of `div_val`+1 system cycles each, starting with a low phase.
- R3: The data line toward the converter carries command bit k during serial clock k+1, for k = 0..7. It changes only together with chip select falling or a falling serial-clock edge, and is low at all other times.
- R4: A conversion whose request did not ask for overlap takes exactly 24 serial clocks. Chip select rises in the system cycle after the falling edge that ends clock 24.
- R5: Result bits are sampled from the converter's output on the rising edges of serial clocks 10 through 23 of that conversion, most significant bit first. Values on that line at any other time have no effect on the result.
- R6: A unipolar result is zero-extended to `OUT_W` bits. A bipolar result is sign-extended from its bit 13.
- R7: `res_valid` is a one-cycle pulse. It is high in the system cycle that starts with the rising edge of the conversion's clock 23, and `res_data` is valid in that cycle.
- R8: `req_ready` is high whenever chip select is high, and otherwise only in the chaining window of R9. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. `busy` is high exactly while chip select is low.
- R9: For a conversion requested with overlap, the chaining window is the last system cycle of serial clock 18. A request taken there starts its start bit on the very next serial clock while chip select stays low. The earlier conversion's result is still delivered in full.
- R10: An overlapped conversion that is not followed by a chained request finishes the full 24-clock frame and then raises chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | DIV_W | Serial clock half-period minus one, in system cycles |
| req_valid | input | 1 | Conversion request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_chan | input | 3 | Channel select field |
| req_single | input | 1 | 1 = single-ended, 0 = differential |
| req_unipolar | input | 1 | 1 = unipolar (straight binary), 0 = bipolar (two's complement) |
| req_pwr | input | 2 | Power-down field passed to the converter |
| req_overlap | input | 1 | Allow the next request to chain at clock 18 |
| busy | output | 1 | Chip select is asserted |
| cs_n | output | 1 | Chip select to the converter, active low |
| sclk | output | 1 | Serial clock to the converter |
| mosi | output | 1 | Command data toward the converter |
| miso | input | 1 | Result data from the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | OUT_W | Extended conversion result |

## Verification
The bench builds the block with DIV_W = 4, RES_W = 14 and OUT_W = 16, and switches `div_val` between 0 and 3 while idle. A setting of 0 makes every serial phase one system cycle long, so the chaining window, the start of the result window and the result strobe sit next to each other in time. A 16-bit output over a 14-bit result puts the two extension bits within reach, so sign extension from bit 13 can be checked. A behavioural converter in the bench decodes each command byte, drives result bits only inside the sampling window and random noise everywhere else, and checks the serial-clock count of every frame, including a three-conversion chain.

// File: rtl/sar_link_pkg.sv
package sar_link_pkg;

  localparam int CMD_W  = 8;
  localparam int CHAN_W = 3;
  localparam int PWR_W  = 2;

  // Command byte: start, channel, single-ended, unipolar, power-down (MSB first)
  function automatic logic [CMD_W-1:0] build_cmd(
    input logic [CHAN_W-1:0] chan,
    input logic              single,
    input logic              unipolar,
    input logic [PWR_W-1:0]  pwr
  );
    return {1'b1, chan, single, unipolar, pwr};
  endfunction

endpackage

// File: rtl/sar_sclk_gen.sv
module sar_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             sclk,
  output logic             rise_ev,
  output logic             fall_ev
);

  logic [DIV_W-1:0] ph_q;
  logic             sclk_q;
  logic             wrap;

  assign wrap    = run && (ph_q == div_val);
  assign rise_ev = wrap && !sclk_q;
  assign fall_ev = wrap && sclk_q;
  assign sclk    = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else if (!run) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else if (wrap) begin
      ph_q   <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      ph_q   <= ph_q + 1'b1;
    end
  end

endmodule

// File: rtl/sar_rx_collect.sv
module sar_rx_collect #(
  parameter int RES_W = 14,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_ev,
  input  logic             start_col,
  input  logic             bip,
  input  logic             miso,
  output logic             res_valid,
  output logic [OUT_W-1:0] res_data
);

  localparam int CNT_W = $clog2(RES_W);

  logic [RES_W-2:0] sh_q;
  logic [CNT_W-1:0] left_q;
  logic             bip_q;

  function automatic logic [OUT_W-1:0] extend_res(input logic [RES_W-1:0] raw,
                                                   input logic bipolar);
    if (bipolar) return {{(OUT_W-RES_W){raw[RES_W-1]}}, raw};
    return {{(OUT_W-RES_W){1'b0}}, raw};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      left_q    <= '0;
      bip_q     <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      if (start_col) begin
        sh_q   <= {{(RES_W-2){1'b0}}, miso};
        left_q <= CNT_W'(RES_W-1);
        bip_q  <= bip;
      end else if (rise_ev && (left_q != '0)) begin
        if (left_q == CNT_W'(1)) begin
          res_valid <= 1'b1;
          res_data  <= extend_res({sh_q, miso}, bip_q);
        end else begin
          sh_q <= {sh_q[RES_W-3:0], miso};
        end
        left_q <= left_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/sar_link_ctrl.sv
module sar_link_ctrl
  import sar_link_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int RES_W     = 14,
  parameter int OUT_W     = 16,
  parameter int OVL_CLKS  = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_W-1:0]    div_val,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [CHAN_W-1:0]   req_chan,
  input  logic                req_single,
  input  logic                req_unipolar,
  input  logic [PWR_W-1:0]    req_pwr,
  input  logic                req_overlap,
  output logic                busy,
  output logic                cs_n,
  output logic                sclk,
  output logic                mosi,
  input  logic                miso,
  output logic                res_valid,
  output logic [OUT_W-1:0]    res_data
);

  localparam int FRAME_CLKS = CMD_W + 1 + RES_W + 1;
  localparam int OFF_W      = $clog2(FRAME_CLKS);
  localparam logic [OFF_W-1:0] OFF_RES_FIRST = OFF_W'(CMD_W + 1);
  localparam logic [OFF_W-1:0] OFF_CHAIN     = OFF_W'(OVL_CLKS - 1);
  localparam logic [OFF_W-1:0] OFF_LAST      = OFF_W'(FRAME_CLKS - 1);

  logic             cs_n_q;
  logic             mosi_q;
  logic [OFF_W-1:0] off_q;
  logic [CMD_W-1:0] tx_q;
  logic             ovl_q;
  logic             bip_q;
  logic             busy_w;
  logic             rise_ev;
  logic             fall_ev;
  logic [CMD_W-1:0] cmd_w;
  logic             chain_win;
  logic             accept;
  logic             frame_end;
  logic             start_col;

  assign busy_w = ~cs_n_q;

  sar_sclk_gen #(.DIV_W(DIV_W)) u_sclk_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy_w),
    .div_val (div_val),
    .sclk    (sclk),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  assign cmd_w     = build_cmd(req_chan, req_single, req_unipolar, req_pwr);
  assign chain_win = busy_w && ovl_q && fall_ev && (off_q == OFF_CHAIN);
  assign req_ready = cs_n_q || chain_win;
  assign accept    = req_valid && req_ready;
  assign frame_end = busy_w && fall_ev && (off_q == OFF_LAST);
  assign start_col = busy_w && rise_ev && (off_q == OFF_RES_FIRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= 1'b1;
      mosi_q <= 1'b0;
      off_q  <= '0;
      tx_q   <= '0;
      ovl_q  <= 1'b0;
      bip_q  <= 1'b0;
    end else if (accept) begin
      cs_n_q <= 1'b0;
      off_q  <= '0;
      ovl_q  <= req_overlap;
      bip_q  <= ~req_unipolar;
      mosi_q <= cmd_w[CMD_W-1];
      tx_q   <= {cmd_w[CMD_W-2:0], 1'b0};
    end else if (frame_end) begin
      cs_n_q <= 1'b1;
      off_q  <= '0;
      mosi_q <= 1'b0;
    end else if (busy_w && fall_ev) begin
      off_q  <= off_q + 1'b1;
      mosi_q <= tx_q[CMD_W-1];
      tx_q   <= {tx_q[CMD_W-2:0], 1'b0};
    end
  end

  sar_rx_collect #(.RES_W(RES_W), .OUT_W(OUT_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_ev   (rise_ev),
    .start_col (start_col),
    .bip       (bip_q),
    .miso      (miso),
    .res_valid (res_valid),
    .res_data  (res_data)
  );

  assign cs_n = cs_n_q;
  assign mosi = mosi_q;
  assign busy = busy_w;

endmodule

// File: rtl/sar_link_checker.sv
module sar_link_checker #(
  parameter int OFF_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sclk,
  input logic             mosi,
  input logic             busy,
  input logic             req_valid,
  input logic             req_ready,
  input logic             res_valid,
  input logic             rise_ev,
  input logic [OFF_W-1:0] off
);

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R2

  AST_MOSI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !mosi); // R3

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R3

  AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rise_ev && (off == '0)) |-> mosi); // R1

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R7

  AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> busy); // R7

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> req_ready); // R8

  AST_ACCEPT_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !cs_n); // R8

endmodule

bind sar_link_ctrl sar_link_checker #(.OFF_W(OFF_W)) u_sar_link_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .mosi      (mosi),
  .busy      (busy),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .res_valid (res_valid),
  .rise_ev   (rise_ev),
  .off       (off_q)
);

// File: tb/test_sar_link_ctrl.sv
module test_sar_link_ctrl;

  localparam int DIV_W = 4;
  localparam int RES_W = 14;
  localparam int OUT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] div_val = '0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [2:0]       req_chan = '0;
  logic             req_single = 1'b0;
  logic             req_unipolar = 1'b0;
  logic [1:0]       req_pwr = '0;
  logic             req_overlap = 1'b0;
  logic             busy, cs_n, sclk, mosi, res_valid;
  logic             miso = 1'b0;
  logic [OUT_W-1:0] res_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sar_link_ctrl #(.DIV_W(DIV_W), .RES_W(RES_W), .OUT_W(OUT_W)) i_sar_link_ctrl (
    .clk(clk), .rst_n(rst_n), .div_val(div_val),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .req_single(req_single), .req_unipolar(req_unipolar), .req_pwr(req_pwr),
    .req_overlap(req_overlap), .busy(busy), .cs_n(cs_n), .sclk(sclk),
    .mosi(mosi), .miso(miso), .res_valid(res_valid), .res_data(res_data)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model (time arithmetic) ----------------
  int        pend_val[$];
  int        dev_cmd[$];
  int        dev_val[$];
  longint    vt[$];
  int        ev[$];
  longint    cyc = 0;
  longint    m_base = 0;
  bit        m_act = 0;
  bit        m_ovl = 0;
  logic [7:0] m_cmd = '0;
  bit        e_cs_n = 1, e_sclk = 0, e_mosi = 0, e_ready = 1, e_busy = 0, e_valid = 0;
  int        e_data = 0;
  int        n_valid = 0;

  always @(posedge clk) begin
    int d;
    longint k;
    longint n;
    int v;
    if (!rst_n) begin
      m_act = 0; cyc = 0;
      e_cs_n = 1; e_sclk = 0; e_mosi = 0; e_ready = 1; e_busy = 0; e_valid = 0;
    end else begin
      d = int'(div_val) + 1;
      if (m_act && (cyc - m_base) == 2 * d * 24 - 1) m_act = 0;
      if (req_valid && e_ready) begin
        m_act  = 1;
        m_base = cyc + 1;
        m_ovl  = req_overlap;
        m_cmd  = 8'(128 + int'(req_chan) * 16 + int'(req_single) * 8
                     + int'(req_unipolar) * 4 + int'(req_pwr));
        v = pend_val.pop_front();
        dev_cmd.push_back(int'(m_cmd));
        dev_val.push_back(v);
        vt.push_back(m_base + 2 * d * 22 + d);
        ev.push_back(req_unipolar ? v : ((v >= 8192) ? v + 49152 : v));
      end
      cyc = cyc + 1;
      k = cyc - m_base;
      e_cs_n = !m_act;
      e_busy = m_act;
      if (m_act) begin
        e_sclk  = ((k / d) % 2) == 1;
        n       = k / (2 * d);
        e_mosi  = (n < 8) ? m_cmd[7 - n] : 1'b0;
        e_ready = m_ovl && (k == 2 * d * 18 - 1);
      end else begin
        e_sclk = 0; e_mosi = 0; e_ready = 1;
      end
      e_valid = 0;
      if (vt.size() > 0 && vt[0] == cyc) begin
        e_valid = 1;
        e_data  = ev[0];
        void'(vt.pop_front());
        void'(ev.pop_front());
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R4 cs_n", int'(cs_n), int'(e_cs_n));
      check("R2 sclk", int'(sclk), int'(e_sclk));
      check("R3 R1 mosi", int'(mosi), int'(e_mosi));
      check("R8 R9 req_ready", int'(req_ready), int'(e_ready));
      check("R8 busy", int'(busy), int'(e_busy));
      check("R7 res_valid", int'(res_valid), int'(e_valid));
      if (e_valid) begin
        n_valid++;
        check("R5 R6 res_data", int'(res_data), e_data);
      end
    end
  end

  // ---------------- behavioural converter ----------------
  int   r = 0;
  int   bc = 0;
  int   st = 0;
  logic [7:0] dsh = '0;
  int   ws[$];
  int   wv[$];
  bit   prev_sclk = 0;
  bit   prev_cs_n = 1;
  int   frame_rises = 0;

  always @(negedge clk) begin
    int i;
    if (cs_n) begin
      if (!prev_cs_n) frame_rises = r;
      r = 0; bc = 0;
      ws.delete(); wv.delete();
      miso <= 1'($urandom);
      prev_sclk = 0;
    end else begin
      if (sclk && !prev_sclk) begin
        r++;
        if (bc == 0) begin
          if (mosi) begin bc = 1; dsh = 8'd1; st = r; end
        end else begin
          dsh = {dsh[6:0], mosi};
          bc++;
          if (bc == 8) begin
            bc = 0;
            if (dev_cmd.size() == 0) check("R1 command byte unexpected", int'(dsh), -1);
            else begin
              check("R1 command byte", int'(dsh), dev_cmd.pop_front());
              ws.push_back(st);
              wv.push_back(dev_val.pop_front());
            end
          end
        end
      end
      if (!sclk && prev_sclk) begin
        miso <= 1'($urandom);
        foreach (ws[j]) begin
          i = r + 1 - ws[j] - 9;
          if (i >= 0 && i <= 13) miso <= 1'((wv[j] >> (13 - i)) & 1);
        end
      end
      prev_sclk = sclk;
    end
    prev_cs_n = cs_n;
  end

  // ---------------- stimulus ----------------
  task automatic send(input int chan, input bit single, input bit uni,
                      input int pwr, input bit ovl, input int val);
    req_chan     = 3'(chan);
    req_single   = single;
    req_unipolar = uni;
    req_pwr      = 2'(pwr);
    req_overlap  = ovl;
    pend_val.push_back(val);
    req_valid    = 1'b1;
    forever begin
      if (req_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!cs_n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int vbase;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset ready", int'(req_ready), 1);
    check("R2 reset sclk", int'(sclk), 0);
    check("R4 reset cs_n", int'(cs_n), 1);
    check("R7 reset valid", int'(res_valid), 0);

    div_val = 4'd0;
    send(3, 1, 1, 0, 0, 16'h2A5F);
    wait_idle();
    check("R4 frame clocks", frame_rises, 24);
    send(5, 0, 0, 2, 0, 16'h3001);   // negative bipolar
    send(6, 1, 0, 1, 0, 16'h0123);   // queued while busy (R8)
    send(0, 0, 1, 3, 0, 16'h3FFF);
    wait_idle();

    div_val = 4'd3;
    send(7, 1, 0, 0, 0, 16'h2000);
    send(2, 0, 1, 0, 0, 16'h0001);
    wait_idle();
    check("R4 frame clocks slow", frame_rises, 24);

    div_val = 4'd1;
    vbase = n_valid;
    send(1, 1, 1, 0, 1, 16'h1555);
    send(4, 0, 0, 0, 1, 16'h2AAA);
    send(6, 1, 0, 2, 1, 16'h3F0F);
    wait_idle();
    check("R9 chained frame clocks", frame_rises, 60);
    check("R9 chained results", n_valid - vbase, 3);

    div_val = 4'd2;
    send(3, 0, 0, 1, 1, 16'h2468);
    wait_idle();
    check("R10 unchained overlap clocks", frame_rises, 24);

    div_val = 4'd0;
    vbase = n_valid;
    send(2, 1, 0, 0, 1, 16'h3333);
    send(5, 1, 1, 0, 1, 16'h0C0C);
    wait_idle();
    check("R9 chained fast clocks", frame_rises, 42);
    check("R9 chained fast results", n_valid - vbase, 2);
    check("R5 R7 all results seen", n_valid, 12);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule